// File: doc/BRIEF.md
# Dual-Clock Real-Time Counter with Synchronized Host Access

This block is an 8-bit counter that can be clocked from a slow, free-running timer clock that has no phase relation to the system clock. The host can also select the system clock as the counter clock. The host sits in the system domain and never touches the counter flops directly. Writes to the compare value and to the control field are staged in system-side shadow registers and carried across by a toggle request and acknowledge pair, which is what drives the busy flags. The count comes back through a holding register that the timer domain refreshes on every one of its clock edges. A compare match toggles an output pin in the timer domain, raises a sticky interrupt flag in the system domain, and one timer cycle later pulses a wake request.

The counter clock feeds a 10-bit prescaler. A 3-bit select field picks either the undivided clock or one prescaler tap, or it stops the counter. A clear bit that travels with the control write restarts the prescaler, so the first tick after the write comes a known number of timer cycles later. Software that comes back from a system-clock stop should write a register and wait for its busy flag to drop before it trusts the read-back value.

Top module: `async_rtc_counter`

## Requirements
- R1: After reset, `rd_count` is 0, both busy flags are low, `irq_flag`, `oc_pin` and `wake_req` are low, and the counter is stopped.
- R2: With `use_async` high the counter logic is clocked by `tmr_clk`. With `use_async` low it is clocked by `clk_sys`, and with select code 1 `rd_count` then grows by exactly one per system cycle.
- R3: The control word is `wr_data[3:0]` written with `wr_sel`=1. Bits [2:0] are the select field. Code 0 freezes the count. Codes 1 to 7 advance the count once every 1, 8, 32, 64, 128, 256 and 1024 counter-clock cycles respectively.
- R4: `rd_count` changes only when a capture toggle arrives from the timer domain. It then shows the count reached at the latest counter-clock edge, and it already equals the compare value when `irq_flag` rises for that match.
- R5: While `clk_sys` is stopped and `tmr_clk` keeps running, `rd_count` is frozen. At the first system edge after the restart it still shows the pre-stop count. It catches up with the live count only after the next `tmr_clk` rising edge has been carried across.
- R6: An accepted write (`wr_sel`=0 for compare, 1 for control) raises the matching busy flag on the next system cycle. The flag drops once the value has been loaded in the timer domain. A write to a register whose busy flag is high is ignored.
- R7: `oc_pin` toggles on the counter-clock edge at which the count steps onto the compare value, with no system-clock retiming.
- R8: `irq_flag` is set at the third `clk_sys` rising edge after the `oc_pin` toggle of a match, and not earlier.
- R9: `irq_flag` stays set until `irq_clr` is sampled high. If a new match arrives in the same cycle as the clear, the set wins.
- R10: `wake_req` is high for exactly one counter-clock cycle. That cycle begins at the counter-clock edge that follows the match edge.
- R11: Control bit 3 set in a control write clears the prescaler when the write lands. With code 6, the first count step comes 256 counter-clock edges after the landing edge, which is the third `tmr_clk` edge after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| tmr_clk | input | 1 | Slow asynchronous timer clock |
| use_async | input | 1 | 1: count on `tmr_clk`, 0: count on `clk_sys` |
| wr_en | input | 1 | Write strobe, one system cycle |
| wr_sel | input | 1 | 0: compare register, 1: control register |
| wr_data | input | 8 | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| rd_count | output | 8 | Synchronized count read-back |
| cmp_busy | output | 1 | Compare write in flight |
| ctl_busy | output | 1 | Control write in flight |
| irq_flag | output | 1 | Sticky compare-match flag, system domain |
| oc_pin | output | 1 | Compare output, toggles in timer domain |
| wake_req | output | 1 | One-timer-cycle wake pulse after a match |

## Verification
The bench counts timer edges between successive read-back changes, so a wrong prescaler tap shows up as a wrong step spacing. A prescaler clear that is missing shows up as a first step at an arbitrary distance from the write. The bench stops the system clock while the timer keeps running. A read-back path that samples the live count instead of the captured one would show the new value at once after the restart. The flag latency is measured against the `oc_pin` toggle, which catches an extra or missing synchronizer stage. A second compare write issued while the flag is busy must not move the match point, and a design that accepts it matches early at the wrong value.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CNT_W = 8;
    localparam int PRE_W = 10;
    localparam int SEL_W = 3;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic             pre_clr;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // log2 of the division ratio picked by each select code
    function automatic int unsigned sel_shift(input logic [SEL_W-1:0] s);
        case (s)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            default: return 10;
        endcase
    endfunction

    // low prescaler bits that must all be ones for a tick
    function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] s);
        return PRE_W'((32'd1 << sel_shift(s)) - 32'd1);
    endfunction

endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 import rtc_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [SYNC_STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_STAGES-2:0], d};
    end

    assign q = sh[SYNC_STAGES-1];
endmodule

// File: rtl/rtc_wr_chan.sv
module rtc_wr_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         ack_tgl,
    output logic [W-1:0] shadow,
    output logic         req_tgl,
    output logic         busy
);
    logic ack_s;

    rtc_sync2 u_ack (.clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s));

    assign busy = req_tgl != ack_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            req_tgl <= 1'b0;
        end else if (wr && !busy) begin
            shadow  <= din;
            req_tgl <= ~req_tgl;
        end
    end

    p_busy_set_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && !busy) |=> busy);
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && busy) |=> $stable(shadow));
endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cmp_shadow,
    input  logic             cmp_req,
    input  ctl_t             ctl_shadow,
    input  logic             ctl_req,
    output logic             cmp_ack,
    output logic             ctl_ack,
    output logic             cap_tgl,
    output logic [CNT_W-1:0] cap_val,
    output logic             match_tgl,
    output logic             oc_pin,
    output logic             wake_req
);
    logic             cmp_rs, cmp_rd, ctl_rs, ctl_rd;
    logic             cmp_load, ctl_load, tick, hit, hit_q;
    logic [PRE_W-1:0] presc;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt, cmp, cnt_nx;

    rtc_sync2 u_cmp_req (.clk(clk), .rst(rst), .d(cmp_req), .q(cmp_rs));
    rtc_sync2 u_ctl_req (.clk(clk), .rst(rst), .d(ctl_req), .q(ctl_rs));

    assign cmp_load = cmp_rs ^ cmp_rd;
    assign ctl_load = ctl_rs ^ ctl_rd;
    assign tick     = (sel != '0) && ((presc & tap_mask(sel)) == tap_mask(sel));
    assign cnt_nx   = cnt + 1'b1;
    assign hit      = tick && (cnt_nx == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_rd    <= 1'b0;
            ctl_rd    <= 1'b0;
            cmp_ack   <= 1'b0;
            ctl_ack   <= 1'b0;
            cmp       <= '0;
            sel       <= '0;
            presc     <= '0;
            cnt       <= '0;
            cap_val   <= '0;
            cap_tgl   <= 1'b0;
            match_tgl <= 1'b0;
            oc_pin    <= 1'b0;
            hit_q     <= 1'b0;
            wake_req  <= 1'b0;
        end else begin
            cmp_rd <= cmp_rs;
            ctl_rd <= ctl_rs;
            if (cmp_load) begin
                cmp     <= cmp_shadow;
                cmp_ack <= cmp_rs;
            end
            if (ctl_load) begin
                sel     <= ctl_shadow.sel;
                ctl_ack <= ctl_rs;
            end
            presc     <= (ctl_load && ctl_shadow.pre_clr) ? '0 : presc + 1'b1;
            if (tick) cnt <= cnt_nx;
            cap_val   <= tick ? cnt_nx : cnt;
            cap_tgl   <= ~cap_tgl;
            match_tgl <= match_tgl ^ hit;
            oc_pin    <= oc_pin ^ hit;
            hit_q     <= hit;
            wake_req  <= hit_q;
        end
    end

    p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |=> $stable(cnt));
    p_oc_match_r7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(oc_pin) && !$past(cmp_load)) |-> (cnt == cmp));
    p_wake_after_r10: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ($past(oc_pin, 2) != $past(oc_pin)));
endmodule

// File: rtl/async_rtc_counter.sv
module async_rtc_counter import rtc_pkg::*; (
    input  logic             clk_sys,
    input  logic             rst,
    input  logic             tmr_clk,
    input  logic             use_async,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] rd_count,
    output logic             cmp_busy,
    output logic             ctl_busy,
    output logic             irq_flag,
    output logic             oc_pin,
    output logic             wake_req
);
    logic             tick_clk, rst_t;
    logic [CNT_W-1:0] cmp_shadow, cap_val;
    logic [CTL_W-1:0] ctl_bits;
    ctl_t             ctl_shadow;
    logic             cmp_req, ctl_req, cmp_ack, ctl_ack;
    logic             cap_tgl, cap_s, cap_d, cap_ld;
    logic             match_tgl, match_s, match_d, match_ld;

    assign tick_clk = use_async ? tmr_clk : clk_sys;

    // reset carried into whichever clock drives the counter
    rtc_sync2 u_rst_t (.clk(tick_clk), .rst(1'b0), .d(rst), .q(rst_t));

    rtc_wr_chan #(.W(CNT_W)) u_cmp_chan (
        .clk(clk_sys), .rst(rst), .wr(wr_en && !wr_sel), .din(wr_data),
        .ack_tgl(cmp_ack), .shadow(cmp_shadow), .req_tgl(cmp_req), .busy(cmp_busy));

    rtc_wr_chan #(.W(CTL_W)) u_ctl_chan (
        .clk(clk_sys), .rst(rst), .wr(wr_en && wr_sel), .din(wr_data[CTL_W-1:0]),
        .ack_tgl(ctl_ack), .shadow(ctl_bits), .req_tgl(ctl_req), .busy(ctl_busy));

    assign ctl_shadow = ctl_t'(ctl_bits);

    rtc_core u_core (
        .clk(tick_clk), .rst(rst_t),
        .cmp_shadow(cmp_shadow), .cmp_req(cmp_req),
        .ctl_shadow(ctl_shadow), .ctl_req(ctl_req),
        .cmp_ack(cmp_ack), .ctl_ack(ctl_ack),
        .cap_tgl(cap_tgl), .cap_val(cap_val),
        .match_tgl(match_tgl), .oc_pin(oc_pin), .wake_req(wake_req));

    rtc_sync2 u_cap_sync   (.clk(clk_sys), .rst(rst), .d(cap_tgl),   .q(cap_s));
    rtc_sync2 u_match_sync (.clk(clk_sys), .rst(rst), .d(match_tgl), .q(match_s));

    assign cap_ld   = cap_s ^ cap_d;
    assign match_ld = match_s ^ match_d;

    always_ff @(posedge clk_sys) begin
        if (rst) begin
            cap_d    <= 1'b0;
            match_d  <= 1'b0;
            rd_count <= '0;
            irq_flag <= 1'b0;
        end else begin
            cap_d    <= cap_s;
            match_d  <= match_s;
            if (cap_ld) rd_count <= cap_val;
            irq_flag <= match_ld | (irq_flag & ~irq_clr);
        end
    end

    p_irq_sticky_r9: assert property (@(posedge clk_sys) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);
    p_irq_clear_r9: assert property (@(posedge clk_sys) disable iff (rst)
        (irq_clr && !match_ld) |=> !irq_flag);
endmodule

// File: tb/async_rtc_counter_tb.sv
`timescale 1ns/100ps
module async_rtc_counter_tb;
    logic       clk_sys = 1'b0, tmr_clk = 1'b0, sys_run = 1'b1;
    logic       rst = 1'b1, use_async = 1'b1, wr_en = 1'b0, wr_sel = 1'b0, irq_clr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_count;
    logic       cmp_busy, ctl_busy, irq_flag, oc_pin, wake_req;
    int         n_checks = 0, n_err = 0, tedge = 0;

    async_rtc_counter u_dut (
        .clk_sys(clk_sys), .rst(rst), .tmr_clk(tmr_clk), .use_async(use_async),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_clr(irq_clr),
        .rd_count(rd_count), .cmp_busy(cmp_busy), .ctl_busy(ctl_busy),
        .irq_flag(irq_flag), .oc_pin(oc_pin), .wake_req(wake_req));

    always #5 if (sys_run) clk_sys = ~clk_sys;
    always #86.5 tmr_clk = ~tmr_clk;
    always @(posedge tmr_clk) tedge <= tedge + 1;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic sel, input logic [7:0] d);
        @(negedge clk_sys);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk_sys);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((cmp_busy || ctl_busy) && n < 2000) begin
            @(negedge clk_sys);
            n++;
        end
        check(req, int'(cmp_busy | ctl_busy), 0);
    endtask

    task automatic settle();
        @(posedge tmr_clk);
        repeat (6) @(negedge clk_sys);
    endtask

    task automatic wait_change(output int t);
        logic [7:0] p = rd_count;
        int n = 0;
        while (rd_count == p && n < 40000) begin
            @(negedge clk_sys);
            n++;
        end
        t = tedge;
    endtask

    task automatic clear_irq();
        @(negedge clk_sys); irq_clr = 1'b1;
        @(negedge clk_sys); irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd_count", int'(rd_count), 0);
        check("R1 busy", int'({cmp_busy, ctl_busy}), 0);
        check("R1 irq/oc/wake", int'({irq_flag, oc_pin, wake_req}), 0);
        repeat (10) @(posedge tmr_clk);
        @(negedge clk_sys);
        check("R1 stopped", int'(rd_count), 0);
    endtask

    task automatic t_prescale();
        int t1, t2;
        do_write(1'b1, 8'h02);
        check("R6 ctl_busy after write", int'(ctl_busy), 1);
        wait_idle("R6 ctl busy clears");
        wait_change(t1); wait_change(t2);
        check("R3 divide by 8", t2 - t1, 8);
        do_write(1'b1, 8'h03);
        wait_idle("R6 ctl busy clears");
        wait_change(t1); wait_change(t2);
        check("R3 divide by 32", t2 - t1, 32);
        do_write(1'b1, 8'h01);
        wait_idle("R6 ctl busy clears");
        wait_change(t1); wait_change(t2);
        check("R3 undivided", t2 - t1, 1);
    endtask

    task automatic t_stop();
        logic [7:0] p;
        do_write(1'b1, 8'h00);
        wait_idle("R6 ctl busy clears");
        settle();
        p = rd_count;
        repeat (30) @(posedge tmr_clk);
        settle();
        check("R3 code 0 freezes", int'(rd_count), int'(p));
    endtask

    task automatic t_preclr();
        int tw, tc;
        @(negedge clk_sys);
        tw = tedge;
        do_write(1'b1, 8'h0E);
        wait_change(tc);
        check("R11 first step after clear", int'((tc - tw) >= 258 && (tc - tw) <= 262), 1);
    endtask

    task automatic t_sync_mode();
        logic [7:0] p, dlt;
        do_write(1'b1, 8'h01);
        wait_idle("R6 ctl busy clears");
        @(negedge clk_sys); use_async = 1'b0;
        repeat (10) @(negedge clk_sys);
        p = rd_count;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk_sys);
            dlt = rd_count - p;
            check("R2 system-clock counting", int'(dlt), 1);
            p = rd_count;
        end
        use_async = 1'b1;
        repeat (10) @(negedge clk_sys);
    endtask

    task automatic t_sleep();
        logic [7:0] p, expv;
        int t0;
        settle();
        p = rd_count; t0 = tedge;
        sys_run = 1'b0;
        repeat (10) @(posedge tmr_clk);
        sys_run = 1'b1;
        @(posedge clk_sys); @(negedge clk_sys);
        check("R5 stale after restart", int'(rd_count), int'(p));
        settle();
        expv = p + 8'(tedge - t0);
        check("R5 refreshed value", int'(rd_count), int'(expv));
    endtask

    task automatic t_compare();
        logic [7:0] c;
        clear_irq();
        c = rd_count + 8'd25;
        do_write(1'b0, c);
        wait_idle("R6 cmp busy clears");
        clear_irq();
        @(oc_pin);
        #0.2;
        check("R10 wake low at match edge", int'(wake_req), 0);
        for (int i = 1; i <= 3; i++) begin
            @(posedge clk_sys); @(negedge clk_sys);
            check("R8 irq latency", int'(irq_flag), (i == 3) ? 1 : 0);
        end
        check("R4 rd equals compare at flag", int'(rd_count), int'(c));
        check("R7 oc toggled", int'(oc_pin), 1);
        @(posedge tmr_clk); #0.2;
        check("R10 wake high next timer cycle", int'(wake_req), 1);
        @(posedge tmr_clk); #0.2;
        check("R10 wake one cycle", int'(wake_req), 0);
        repeat (20) @(negedge clk_sys);
        check("R9 flag sticky", int'(irq_flag), 1);
        clear_irq();
        check("R9 flag cleared", int'(irq_flag), 0);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] a, b;
        a = rd_count + 8'd30;
        b = rd_count + 8'd12;
        do_write(1'b0, a);
        check("R6 cmp_busy after write", int'(cmp_busy), 1);
        do_write(1'b0, b);
        wait_idle("R6 cmp busy clears");
        clear_irq();
        @(oc_pin);
        repeat (3) begin
            @(posedge clk_sys); @(negedge clk_sys);
        end
        check("R6 write during busy ignored", int'(rd_count), int'(a));
        check("R8 flag for kept compare", int'(irq_flag), 1);
    endtask

    initial begin
        repeat (100) @(negedge clk_sys);
        rst = 1'b0;
        repeat (60) @(negedge clk_sys);
        t_reset();
        t_prescale();
        t_stop();
        t_preclr();
        t_sync_mode();
        t_sleep();
        t_compare();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #1500000;
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule